// File: doc/BRIEF.md
# Microcoded Single-Bus Double-Indirect Load Controller

A horizontal-microcode sequencer steers a datapath built around one shared 32-bit bus. The datapath holds a 32-entry register file, a program counter, A and B operand latches, an adder, an instruction register, a memory-address register and a small word-organised memory. Each microword carries load enables, bus-drive enables, an adder operation, a branch type and a jump target. The microprogram covers instruction fetch, dispatch on the opcode, a one-step no-op and a double-indirect load. The load sets register rd to the word stored at the address found in memory at address R[rs]. Memory is as fast as the register file, so no microword ever waits.

While `run_i` is low, the sequencer stays parked at the first fetch step and no architectural state changes. In this state the memory can be filled through a preload port. A debug read port lets the registers be seen from outside.

Instruction word: opcode in bits [31:26], rs in bits [25:21], rd in bits [20:16].

Top module: `ucode_bus_core`

## Requirements
- R1: After reset, PC is 0, the microaddress is 0 (first fetch step), and register i holds 0x80 + 4*i.
- R2: Fetch takes exactly three microcycles, with microaddresses 0, 1 and 2. PC is written with PC+4 at the end of the third one.
- R3: Dispatch uses opcode bits [31:26]. Opcode 0x00 goes to the no-op at microaddress 3. Opcode 0x3A goes to the load at microaddress 4. Any other opcode returns to microaddress 0, so the whole instruction lasts three cycles and changes only PC.
- R4: The no-op is a single microcycle (microaddress 3) that changes no register and jumps back to microaddress 0. The whole instruction lasts four cycles.
- R5: The double-indirect load sets R[rd] = M[M[R[rs]]] (rs in bits [25:21], rd in bits [20:16]). It runs through microaddresses 4, 5 and 6 and then returns to 0, so the whole instruction lasts six cycles.
- R6: An executed instruction changes no register except rd and PC. When rs equals rd, the chain starts from the old value of rs. A later instruction sees the value the earlier load wrote.
- R7: No microword enables more than one bus driver.
- R8: A memory access uses address bits [7:2] as the word index. Address bits [1:0] and bits above 7 are ignored, so addresses wrap modulo 256 bytes.
- R9: While `run_i` is low, the microaddress is held at 0 and PC and the registers keep their values. In this state, `init_we_i` writes `init_data_i` to memory word `init_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables execution; low parks the sequencer |
| init_we_i | input | 1 | Memory preload write strobe (taken only when run_i is low) |
| init_addr_i | input | 6 | Memory preload word index |
| init_data_i | input | 32 | Memory preload data |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | 32 | Value of the selected register |
| pc_o | output | 32 | Program counter |
| upc_o | output | 3 | Current microaddress |

## Verification
The bench goes after the pointer-chain cases that a careless microprogram gets wrong. When rs equals rd, a design that wrote rd early would follow the wrong chain. A pointer that refers to its own word is read twice from the same place. A pointer with low bits set, or with bits above the memory range, must lose those bits, or the design reads the wrong word. Back-to-back instructions check that PC steps by four each time and that a second load sees the register the first one wrote. Unknown opcodes and the no-op are timed cycle by cycle. A bad dispatch target or a stray register write shows up as a wrong microaddress or a changed register.

// File: rtl/ucode_bus_pkg.sv
package ucode_bus_pkg;
  localparam int UA_W = 3;
  typedef logic [UA_W-1:0] uaddr_t;

  localparam uaddr_t UA_FETCH0 = 3'd0;
  localparam uaddr_t UA_FETCH1 = 3'd1;
  localparam uaddr_t UA_FETCH2 = 3'd2;
  localparam uaddr_t UA_NOP0   = 3'd3;
  localparam uaddr_t UA_LDII0  = 3'd4;
  localparam uaddr_t UA_LDII1  = 3'd5;
  localparam uaddr_t UA_LDII2  = 3'd6;

  localparam logic [5:0] OP_NOP  = 6'h00;
  localparam logic [5:0] OP_LDII = 6'h3A;

  typedef enum logic [1:0] {BR_NEXT, BR_JUMP, BR_DISP} br_e;
  typedef enum logic [1:0] {SEL_RS, SEL_RD, SEL_PC} rsel_e;
  typedef enum logic {ALU_ADD, ALU_INC4} alu_e;

  typedef struct packed {
    logic   ld_ir;
    rsel_e  reg_sel;
    logic   reg_wr;
    logic   en_reg;
    logic   ld_a;
    logic   ld_b;
    alu_e   alu_op;
    logic   en_alu;
    logic   ld_ma;
    logic   mem_wr;
    logic   en_mem;
    logic   ex_sgn;
    logic   en_imm;
    br_e    br;
    uaddr_t next;
  } uword_t;
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_bus_pkg::*;
(
  input  uaddr_t upc_i,
  output uword_t uw_o
);
  always_comb begin
    uw_o = '0;
    unique case (upc_i)
      UA_FETCH0: begin  // MA <- PC, A <- PC
        uw_o.reg_sel = SEL_PC; uw_o.en_reg = 1'b1;
        uw_o.ld_ma = 1'b1; uw_o.ld_a = 1'b1; uw_o.br = BR_NEXT;
      end
      UA_FETCH1: begin  // IR <- M[MA]
        uw_o.en_mem = 1'b1; uw_o.ld_ir = 1'b1; uw_o.br = BR_NEXT;
      end
      UA_FETCH2: begin  // PC <- A+4, dispatch
        uw_o.alu_op = ALU_INC4; uw_o.en_alu = 1'b1;
        uw_o.reg_sel = SEL_PC; uw_o.reg_wr = 1'b1; uw_o.br = BR_DISP;
      end
      UA_NOP0: begin
        uw_o.br = BR_JUMP; uw_o.next = UA_FETCH0;
      end
      UA_LDII0: begin   // MA <- R[rs]
        uw_o.reg_sel = SEL_RS; uw_o.en_reg = 1'b1;
        uw_o.ld_ma = 1'b1; uw_o.br = BR_NEXT;
      end
      UA_LDII1: begin   // MA <- M[MA]
        uw_o.en_mem = 1'b1; uw_o.ld_ma = 1'b1; uw_o.br = BR_NEXT;
      end
      UA_LDII2: begin   // R[rd] <- M[MA], back to fetch
        uw_o.en_mem = 1'b1; uw_o.reg_sel = SEL_RD; uw_o.reg_wr = 1'b1;
        uw_o.br = BR_JUMP; uw_o.next = UA_FETCH0;
      end
      default: begin
        uw_o.br = BR_JUMP; uw_o.next = UA_FETCH0;
      end
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  br_e        br_i,
  input  uaddr_t     next_i,
  input  logic [5:0] opcode_i,
  output uaddr_t     upc_o
);
  uaddr_t upc_q, upc_d, disp;

  always_comb begin
    unique case (opcode_i)
      OP_NOP:  disp = UA_NOP0;
      OP_LDII: disp = UA_LDII0;
      default: disp = UA_FETCH0;
    endcase
  end

  always_comb begin
    unique case (br_i)
      BR_NEXT: upc_d = upc_q + uaddr_t'(1);
      BR_JUMP: upc_d = next_i;
      default: upc_d = disp;
    endcase
    if (!run_i) upc_d = UA_FETCH0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) upc_q <= UA_FETCH0;
    else         upc_q <= upc_d;

  assign upc_o = upc_q;
endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
  import ucode_bus_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NREGS     = 32,
  parameter int MEM_WORDS = 64,
  parameter int unsigned REG_BASE = 32'h80,
  localparam int RIW = $clog2(NREGS),
  localparam int MAW = $clog2(MEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  uword_t          uw_i,
  input  logic            init_we_i,
  input  logic [MAW-1:0]  init_addr_i,
  input  logic [XLEN-1:0] init_data_i,
  input  logic [RIW-1:0]  dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic [XLEN-1:0] pc_o,
  output logic [5:0]      opcode_o
);
  logic [XLEN-1:0] rf [NREGS];
  logic [XLEN-1:0] mem [MEM_WORDS];
  logic [XLEN-1:0] pc_q, a_q, b_q, ir_q, ma_q;
  logic [XLEN-1:0] bus, reg_rd, alu_out, imm, mem_rd;
  logic [RIW-1:0]  ridx;
  logic [MAW-1:0]  widx;

  assign ridx   = (uw_i.reg_sel == SEL_RD) ? ir_q[16 +: RIW] : ir_q[21 +: RIW];
  assign reg_rd = (uw_i.reg_sel == SEL_PC) ? pc_q : rf[ridx];
  assign widx   = ma_q[2 +: MAW];
  assign mem_rd = mem[widx];
  assign alu_out = a_q + ((uw_i.alu_op == ALU_INC4) ? XLEN'(4) : b_q);
  assign imm = uw_i.ex_sgn ? {{(XLEN-16){ir_q[15]}}, ir_q[15:0]}
                           : {{(XLEN-16){1'b0}}, ir_q[15:0]};

  always_comb begin
    if      (uw_i.en_reg) bus = reg_rd;
    else if (uw_i.en_alu) bus = alu_out;
    else if (uw_i.en_mem) bus = mem_rd;
    else if (uw_i.en_imm) bus = imm;
    else                  bus = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; a_q <= '0; b_q <= '0; ir_q <= '0; ma_q <= '0;
      for (int i = 0; i < NREGS; i++) rf[i] <= XLEN'(REG_BASE) + XLEN'(4 * i);
    end else if (run_i) begin
      if (uw_i.ld_ir) ir_q <= bus;
      if (uw_i.ld_a)  a_q  <= bus;
      if (uw_i.ld_b)  b_q  <= bus;
      if (uw_i.ld_ma) ma_q <= bus;
      if (uw_i.reg_wr) begin
        if (uw_i.reg_sel == SEL_PC) pc_q <= bus;
        else                        rf[ridx] <= bus;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!run_i && init_we_i)      mem[init_addr_i] <= init_data_i;
    else if (run_i && uw_i.mem_wr) mem[widx] <= bus;
  end

  assign dbg_data_o = rf[dbg_addr_i];
  assign pc_o       = pc_q;
  assign opcode_o   = ir_q[31:26];
endmodule

// File: rtl/ucode_bus_core.sv
module ucode_bus_core
  import ucode_bus_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NREGS     = 32,
  parameter int MEM_WORDS = 64,
  parameter int unsigned REG_BASE = 32'h80,
  localparam int RIW = $clog2(NREGS),
  localparam int MAW = $clog2(MEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            init_we_i,
  input  logic [MAW-1:0]  init_addr_i,
  input  logic [XLEN-1:0] init_data_i,
  input  logic [RIW-1:0]  dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  output logic [XLEN-1:0] pc_o,
  output logic [UA_W-1:0] upc_o
);
  uword_t     uw;
  uaddr_t     upc;
  logic [5:0] opcode;

  ucode_rom u_rom (.upc_i(upc), .uw_o(uw));

  ucode_seq u_seq (
    .clk_i, .rst_ni, .run_i,
    .br_i(uw.br), .next_i(uw.next), .opcode_i(opcode), .upc_o(upc)
  );

  ucode_datapath #(
    .XLEN(XLEN), .NREGS(NREGS), .MEM_WORDS(MEM_WORDS), .REG_BASE(REG_BASE)
  ) u_dp (
    .clk_i, .rst_ni, .run_i, .uw_i(uw),
    .init_we_i, .init_addr_i, .init_data_i,
    .dbg_addr_i, .dbg_data_o, .pc_o, .opcode_o(opcode)
  );

  assign upc_o = upc;
endmodule

// File: rtl/ucode_bus_chk.sv
module ucode_bus_chk #(parameter int XLEN = 32) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            run_i,
  input logic [XLEN-1:0] pc_o,
  input logic [2:0]      upc_o,
  input logic [3:0]      drv_en
);
  a_r7_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_en));

  a_r2_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 3'd0 && run_i) |=> (upc_o == 3'd1));

  a_r2_pc_only_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_o) |-> ($past(upc_o) == 3'd2 && $past(run_i)));

  a_r5_ld_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 3'd4 && run_i) |=> (upc_o == 3'd5));

  a_r5_ld_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 3'd6) |=> (upc_o == 3'd0));

  a_r4_nop_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 3'd3) |=> (upc_o == 3'd0));

  a_r9_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (upc_o == 3'd0 && $stable(pc_o)));
endmodule

bind ucode_bus_core ucode_bus_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .pc_o(pc_o), .upc_o(upc_o),
  .drv_en({uw.en_reg, uw.en_alu, uw.en_mem, uw.en_imm})
);

// File: tb/ucode_bus_core_tb_top.sv
module ucode_bus_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 1'b0;
  logic        init_we = 1'b0;
  logic [5:0]  init_addr = '0;
  logic [31:0] init_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data, pc;
  logic [2:0]  upc;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ucode_bus_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .init_we_i(init_we),
    .init_addr_i(init_addr), .init_data_i(init_data),
    .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data), .pc_o(pc), .upc_o(upc)
  );

  localparam logic [5:0] OP_NOP = 6'h00, OP_LDII = 6'h3A, OP_BAD = 6'h15;

  // {rs, rd, ptr, data}
  localparam int NV = 5;
  localparam logic [73:0] VEC [NV] = '{
    {5'd1,  5'd2,  32'h0000_00C0, 32'hDEAD_BEEF},
    {5'd7,  5'd7,  32'h0000_00B0, 32'h1234_5678},  // rs==rd
    {5'd0,  5'd31, 32'h0000_0080, 32'h0000_0080},  // self pointer
    {5'd10, 5'd3,  32'h0000_00E3, 32'h0F0F_0F0F},  // low bits set
    {5'd31, 5'd0,  32'h0000_0190, 32'hA5A5_A5A5}   // wraps above 256
  };

  function automatic logic [31:0] rst_val(int i);
    return 32'h80 + 32'(4 * i);
  endfunction
  function automatic logic [31:0] instr(logic [5:0] op, logic [4:0] rs, logic [4:0] rd);
    return {op, rs, rd, 16'h0};
  endfunction
  function automatic logic [5:0] widx(logic [31:0] a);
    return a[7:2];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; run = 1'b0; init_we = 1'b0;
    step(2); rst_ni = 1'b1; step(1);
  endtask

  task automatic mem_wr(logic [5:0] a, logic [31:0] d);
    init_we = 1'b1; init_addr = a; init_data = d; step(1); init_we = 1'b0;
  endtask

  task automatic run_cycles(int n);
    run = 1'b1; step(n); run = 1'b0;
  endtask

  function automatic logic [31:0] rd_reg(int i);
    return 32'h0;
  endfunction

  // check registers other than the listed ones keep reset values
  task automatic chk_others(string req, int skip_a, int skip_b);
    int bad = 0;
    logic [31:0] bad_act = '0, bad_exp = '0;
    for (int i = 0; i < 32; i++) begin
      if (i == skip_a || i == skip_b) continue;
      dbg_addr = 5'(i); #1;
      if (dbg_data !== rst_val(i) && bad == 0) begin
        bad = 1; bad_act = dbg_data; bad_exp = rst_val(i);
      end
    end
    chk(req, bad_act, bad_exp);
  endtask

  task automatic chk_reg(string req, int i, logic [31:0] exp);
    dbg_addr = 5'(i); #1;
    chk(req, dbg_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 pc", pc, 32'h0);
    chk("R1 upc", 32'(upc), 32'd0);
    chk_reg("R1 r5", 5, 32'h94);

    // R9 parked while run low
    step(5);
    chk("R9 upc held", 32'(upc), 32'd0);
    chk("R9 pc held", pc, 32'h0);
    chk_others("R9 regs held", -1, -1);

    // Vector table: one double-indirect load each (R5, R6, R8)
    for (int v = 0; v < NV; v++) begin
      logic [4:0] rs, rd;
      logic [31:0] ptr, dat;
      {rs, rd, ptr, dat} = VEC[v];
      do_reset();
      mem_wr(6'd0, instr(OP_LDII, rs, rd));
      mem_wr(widx(rst_val(rs)), ptr);
      mem_wr(widx(ptr), dat);
      run_cycles(6);
      chk_reg("R5 R8 rd value", rd, dat);
      chk("R5 back at fetch", 32'(upc), 32'd0);
      chk("R2 pc+4", pc, 32'h4);
      chk_others("R6 others unchanged", rd, -1);
    end

    // R2/R3/R4 no-op timing
    do_reset();
    mem_wr(6'd0, instr(OP_NOP, 5'd3, 5'd4));
    run = 1'b1;
    step(1); chk("R2 fetch1", 32'(upc), 32'd1);
    step(1); chk("R2 fetch2", 32'(upc), 32'd2);
    chk("R2 pc before write", pc, 32'h0);
    step(1); chk("R3 nop dispatch", 32'(upc), 32'd3);
    chk("R2 pc written", pc, 32'h4);
    step(1); chk("R4 nop return", 32'(upc), 32'd0);
    run = 1'b0;
    chk_others("R4 nop no reg change", -1, -1);

    // R3 unknown opcode
    do_reset();
    mem_wr(6'd0, instr(OP_BAD, 5'd1, 5'd2));
    run_cycles(3);
    chk("R3 unknown returns", 32'(upc), 32'd0);
    chk("R3 unknown pc", pc, 32'h4);
    chk_others("R3 unknown no reg change", -1, -1);

    // R6 back-to-back: load, nop, load using prior result
    do_reset();
    mem_wr(6'd0, instr(OP_LDII, 5'd2, 5'd4));
    mem_wr(6'd1, instr(OP_NOP, 5'd0, 5'd0));
    mem_wr(6'd2, instr(OP_LDII, 5'd4, 5'd5));
    mem_wr(6'd34, 32'hA8);
    mem_wr(6'd42, 32'hC8);
    mem_wr(6'd50, 32'hD0);
    mem_wr(6'd52, 32'h0000_55AA);
    run_cycles(16);
    chk_reg("R6 first load", 4, 32'hC8);
    chk_reg("R6 chained load", 5, 32'h55AA);
    chk("R6 pc after three", pc, 32'hC);
    chk_others("R6 seq others unchanged", 4, 5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule